// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a synchronous static RAM with zero-wait bus turnaround. Address, control and byte-lane enables are sampled on the rising clock edge. Write data arrives later than its address ("late write"), so a read may directly follow a write, and a write may directly follow a read, with no idle cycle between them. Every bus cycle can therefore carry data.

A static mode input selects the read timing. Pipelined timing adds an output register and returns read data one edge later than flow-through timing. The late-write distance follows the same mode: one edge in flow-through, two edges in pipelined.

The core also provides four-beat bursts with linear or interleaved address order, nine-bit byte-lane writes, three chip enables of mixed polarity for depth expansion, an asynchronous output enable and an asynchronous sleep input. A read to a word with a write still in flight returns the newer data, merged lane by lane. The bidirectional data pins are modelled as a data-out bus plus a drive flag.

Top module: `nbt_sram`

## Requirements
- R1: With `pipe_mode`=0, a read sampled at edge k has `dvalid`=1 and its word on `dout` after edge k, where it is captured at edge k+1.
- R2: With `pipe_mode`=1, a read sampled at edge k has `dvalid`=1 and its word on `dout` after edge k+1.
- R3: Write data on `din` is taken at the first edge after the write's address edge when `pipe_mode`=0, and at the second edge after it when `pipe_mode`=1.
- R4: Reads and writes may follow each other in any order on consecutive edges. A read always returns the most recent earlier write to that word, including a write whose data has not yet been committed, merged lane by lane.
- R5: `bw_n[i]`=0 writes lane i, which is bits [9i+8:9i]. Lanes whose bit is 1 keep their old contents.
- R6: A new access is taken only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0 with `adv`=0. Any other chip-enable combination with `adv`=0 is a deselect: nothing is written, nothing is driven, and any burst ends.
- R7: `adv`=1 continues the current burst from the internal beat counter. It ignores `addr`, `we_n` and the chip enables, and keeps the read or write type of the cycle that opened the burst. `adv`=1 with no burst open does nothing.
- R8: With `burst_ilv`=0, the low two address bits of beat b are (start + b) mod 4, and the upper bits stay fixed.
- R9: With `burst_ilv`=1, the low two address bits of beat b are start XOR b.
- R10: `oe_n`=1 forces `dvalid`=0 and `dout`=0 at once, whatever the state of the read pipeline.
- R11: While `sleep`=1, edges start or advance no access, `dvalid`=0, and the array contents are kept.
- R12: Synchronous reset clears the output valid state, closes any burst and drops pending writes. During and right after reset, `dvalid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 1 selects pipelined timing, 0 selects flow-through timing (static) |
| burst_ilv | input | 1 | 1 selects interleaved burst order, 0 selects linear (static) |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| adv | input | 1 | Burst continue |
| we_n | input | 1 | 0 = write, 1 = read, sampled when a new access starts |
| bw_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dvalid | output | 1 | Drive flag for `dout` |

## Verification
The collision that matters is a read that lands in the same cycle as a pending write's data commit, or just before it, on the same word. In pipelined mode, this means a write to word W followed on the next edge by a read of W, whose data is not known until one edge after the read was sampled. The bench provokes this by alternating writes and partial-lane writes with reads of the same address on back-to-back edges, in both timing modes. It judges the result against a reference memory that is updated at the edge where each write's data is due, and read at the edge where each read's data must appear.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  localparam int BURST_BITS = 2;

  function automatic logic [BURST_BITS-1:0] burst_low(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] beat,
    input logic                  ilv
  );
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/nbt_cmd_decode.sv
module nbt_cmd_decode
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              ilv,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              ce2_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_t         acc_kind,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  acc_lanes
);

  logic                  chip_sel;
  logic                  brst_act_q;
  logic                  brst_wr_q;
  logic [ADDR_W-1:0]     brst_base_q;
  logic [BURST_BITS-1:0] brst_beat_q;
  logic [BURST_BITS-1:0] next_beat;

  assign chip_sel  = !ce0_n && ce1 && !ce2_n;
  assign next_beat = brst_beat_q + 1'b1;
  assign acc_lanes = ~bw_n;

  always_comb begin
    acc_kind = ACC_IDLE;
    acc_addr = addr;
    if (!rst && !sleep) begin
      if (adv) begin
        if (brst_act_q) begin
          acc_kind = brst_wr_q ? ACC_WRITE : ACC_READ;
          acc_addr = {brst_base_q[ADDR_W-1:BURST_BITS],
                      burst_low(brst_base_q[BURST_BITS-1:0], next_beat, ilv)};
        end
      end else if (chip_sel) begin
        acc_kind = we_n ? ACC_READ : ACC_WRITE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brst_act_q  <= 1'b0;
      brst_wr_q   <= 1'b0;
      brst_base_q <= '0;
      brst_beat_q <= '0;
    end else if (!sleep) begin
      if (adv) begin
        if (brst_act_q) brst_beat_q <= next_beat;
      end else if (chip_sel) begin
        brst_act_q  <= 1'b1;
        brst_wr_q   <= !we_n;
        brst_base_q <= addr;
        brst_beat_q <= '0;
      end else begin
        brst_act_q <= 1'b0;
      end
    end
  end

  // A deselect without a continuation must produce no access (R6)
  assert_deselect_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !adv && (ce0_n || !ce1 || ce2_n)) |-> acc_kind == ACC_IDLE);

  // A continuation right after a deselect has no burst to continue (R7)
  assert_orphan_adv_R7: assert property (@(posedge clk) disable iff (rst)
    (!sleep && adv && $past(!sleep && !adv && (ce0_n || !ce1 || ce2_n)))
      |-> acc_kind == ACC_IDLE);

endmodule

// File: rtl/nbt_write_queue.sv
module nbt_write_queue #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_mode,
  input  logic              wr_v,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lanes,
  output logic              cm_v,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [LANES-1:0]  cm_lanes
);

  localparam int STAGES = 2;

  logic [STAGES-1:0] v_q;
  logic [ADDR_W-1:0] a_q [STAGES];
  logic [LANES-1:0]  l_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else     v_q <= {v_q[STAGES-2:0], wr_v};
    a_q[0] <= wr_addr;
    l_q[0] <= wr_lanes;
    for (int s = 1; s < STAGES; s++) begin
      a_q[s] <= a_q[s-1];
      l_q[s] <= l_q[s-1];
    end
  end

  always_comb begin
    if (pipe_mode) begin
      cm_v     = v_q[STAGES-1];
      cm_addr  = a_q[STAGES-1];
      cm_lanes = l_q[STAGES-1];
    end else begin
      cm_v     = v_q[0];
      cm_addr  = a_q[0];
      cm_lanes = l_q[0];
    end
  end

endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANES*LANE_W-1:0]   rd_data,
  input  logic [LANES-1:0]          wr_lanes,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANES*LANE_W-1:0]   wr_data
);

  localparam int WORDS  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
    for (int l = 0; l < LANES; l++) begin
      if (wr_lanes[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
    end
  end

endmodule

// File: rtl/nbt_read_path.sv
module nbt_read_path #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pipe_mode,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic                    rd_v,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANES*LANE_W-1:0] rd_raw,
  input  logic [LANES-1:0]        cm_lanes,
  input  logic [ADDR_W-1:0]       cm_addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dvalid
);

  localparam int DATA_W = LANES * LANE_W;

  logic              s1_v_q;
  logic [ADDR_W-1:0] s1_a_q;
  logic [LANES-1:0]  s1_byp_q;
  logic [DATA_W-1:0] s1_bd_q;
  logic [DATA_W-1:0] s1_word;
  logic [DATA_W-1:0] o_word_d;
  logic [DATA_W-1:0] o_d_q;
  logic              o_v_q;
  logic [LANES-1:0]  late_hit;
  logic              pick_v;
  logic [DATA_W-1:0] pick_d;

  assign late_hit = (s1_v_q && cm_addr == s1_a_q) ? cm_lanes : '0;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_merge
      assign s1_word[l*LANE_W +: LANE_W] =
        s1_byp_q[l] ? s1_bd_q[l*LANE_W +: LANE_W] : rd_raw[l*LANE_W +: LANE_W];
      assign o_word_d[l*LANE_W +: LANE_W] =
        late_hit[l] ? din[l*LANE_W +: LANE_W] : s1_word[l*LANE_W +: LANE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v_q <= 1'b0;
      o_v_q  <= 1'b0;
    end else begin
      s1_v_q <= rd_v;
      o_v_q  <= s1_v_q;
    end
    s1_a_q   <= rd_addr;
    s1_byp_q <= (rd_v && cm_addr == rd_addr) ? cm_lanes : '0;
    s1_bd_q  <= din;
    o_d_q    <= o_word_d;
  end

  assign pick_v = pipe_mode ? o_v_q : s1_v_q;
  assign pick_d = pipe_mode ? o_d_q : s1_word;
  assign dvalid = pick_v && !oe_n && !sleep;
  assign dout   = dvalid ? pick_d : '0;

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pipe_mode,
  input  logic                    burst_ilv,
  input  logic                    ce0_n,
  input  logic                    ce1,
  input  logic                    ce2_n,
  input  logic                    adv,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dvalid
);

  localparam int DATA_W = LANES * LANE_W;

  acc_kind_t         acc_kind;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_lanes;
  logic              cm_v;
  logic [ADDR_W-1:0] cm_addr;
  logic [LANES-1:0]  cm_lanes;
  logic [LANES-1:0]  cm_lanes_g;
  logic [DATA_W-1:0] rd_raw;

  assign cm_lanes_g = cm_lanes & {LANES{cm_v}};

  nbt_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .clk(clk), .rst(rst), .sleep(sleep), .ilv(burst_ilv),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .adv(adv), .we_n(we_n),
    .bw_n(bw_n), .addr(addr),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_lanes(acc_lanes)
  );

  nbt_write_queue #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wq (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode),
    .wr_v(acc_kind == ACC_WRITE), .wr_addr(acc_addr), .wr_lanes(acc_lanes),
    .cm_v(cm_v), .cm_addr(cm_addr), .cm_lanes(cm_lanes)
  );

  nbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rd_addr(acc_addr), .rd_data(rd_raw),
    .wr_lanes(cm_lanes_g), .wr_addr(cm_addr), .wr_data(din)
  );

  nbt_read_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .oe_n(oe_n), .sleep(sleep),
    .rd_v(acc_kind == ACC_READ), .rd_addr(acc_addr), .rd_raw(rd_raw),
    .cm_lanes(cm_lanes_g), .cm_addr(cm_addr), .din(din),
    .dout(dout), .dvalid(dvalid)
  );

  // Flow-through read data is driven in the cycle after its address edge (R1)
  assert_flow_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && $past(acc_kind == ACC_READ) && !oe_n && !sleep) |-> dvalid);

  // Pipelined read data is driven one edge later (R2)
  assert_pipe_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && $past(acc_kind == ACC_READ, 2) && !oe_n && !sleep) |-> dvalid);

  // Single late write: a commit follows a write address by one edge (R3)
  assert_single_late_R3: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && cm_v) |-> $past(acc_kind == ACC_WRITE));

  // Double late write: a commit follows a write address by two edges (R3)
  assert_double_late_R3: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && cm_v) |-> $past(acc_kind == ACC_WRITE, 2));

endmodule

// File: tb/nbt_sram_test.sv
module nbt_sram_test;

  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam logic [2:0] SEL = 3'b010;
  localparam logic [2:0] DES = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pipe_mode = 1'b0;
  logic burst_ilv = 1'b0;
  logic ce0_n = 1'b1;
  logic ce1 = 1'b0;
  logic ce2_n = 1'b1;
  logic adv = 1'b0;
  logic we_n = 1'b1;
  logic oe_n = 1'b0;
  logic sleep = 1'b0;
  logic [LN-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dvalid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R12";

  logic [DW-1:0] ref_mem [1<<AW];
  logic          pw_v [8];
  logic [AW-1:0] pw_a [8];
  logic [LN-1:0] pw_l [8];
  logic [DW-1:0] pw_d [8];
  logic          ro_v [8];
  logic [AW-1:0] ro_a [8];
  logic          m_act = 1'b0;
  logic          m_wr = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;

  always #2 clk = ~clk;

  nbt_sram uut (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .adv(adv), .we_n(we_n),
    .bw_n(bw_n), .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dvalid(dvalid)
  );

  task automatic check(input logic ev, input logic [DW-1:0] ed);
    checks++;
    if (dvalid !== ev || dout !== (ev ? ed : '0)) begin
      errors++;
      $display("FAIL %s: got valid=%0b data=%h expected valid=%0b data=%h",
               cur_req, dvalid, dout, ev, ev ? ed : '0);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < 8; s++) begin
      pw_v[s] = 1'b0;
      ro_v[s] = 1'b0;
    end
    m_act = 1'b0;
  endtask

  // One bus cycle: drive inputs, pass one edge, update the reference, check outputs
  task automatic step(input logic a_adv, input logic [2:0] a_ce, input logic a_we_n,
                      input logic [LN-1:0] a_bw_n, input logic [AW-1:0] a_addr,
                      input logic [DW-1:0] a_data);
    int c;
    int ws;
    int rs;
    logic kw;
    logic kr;
    logic ev;
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    c = cyc + 1;
    kw = 1'b0;
    kr = 1'b0;
    ea = a_addr;
    if (!sleep) begin
      if (a_adv) begin
        if (m_act) begin
          m_beat = m_beat + 2'd1;
          ea = {m_base[AW-1:2], burst_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat)};
          kw = m_wr;
          kr = !m_wr;
        end
      end else if (a_ce == SEL) begin
        m_act = 1'b1;
        m_base = a_addr;
        m_beat = 2'd0;
        m_wr = !a_we_n;
        kw = !a_we_n;
        kr = a_we_n;
      end else begin
        m_act = 1'b0;
      end
    end
    if (kw) begin
      ws = (c + (pipe_mode ? 2 : 1)) % 8;
      pw_v[ws] = 1'b1;
      pw_a[ws] = ea;
      pw_l[ws] = ~a_bw_n;
      pw_d[ws] = a_data;
    end
    if (kr) begin
      rs = (c + (pipe_mode ? 1 : 0)) % 8;
      ro_v[rs] = 1'b1;
      ro_a[rs] = ea;
    end
    adv = a_adv;
    we_n = a_we_n;
    bw_n = a_bw_n;
    addr = a_addr;
    {ce0_n, ce1, ce2_n} = a_ce;
    din = pw_v[c % 8] ? pw_d[c % 8] : (36'h5A5A5A5A5 ^ DW'(c * 7919));
    @(posedge clk);
    @(negedge clk);
    cyc = c;
    if (pw_v[c % 8]) begin
      for (int l = 0; l < LN; l++)
        if (pw_l[c % 8][l]) ref_mem[pw_a[c % 8]][l*LW +: LW] = pw_d[c % 8][l*LW +: LW];
      pw_v[c % 8] = 1'b0;
    end
    ev = ro_v[c % 8] && !oe_n && !sleep;
    ed = ev ? ref_mem[ro_a[c % 8]] : '0;
    ro_v[c % 8] = 1'b0;
    check(ev, ed);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] b);
    step(1'b0, SEL, 1'b0, b, a, d);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    step(1'b0, SEL, 1'b1, '1, a, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, DES, 1'b1, '1, '0, '0);
  endtask

  // Continuation with misleading addr, we_n and chip enables, which must all be ignored
  task automatic cont(input logic [DW-1:0] d);
    step(1'b1, DES, ~we_n, '0, 8'hEE, d);
  endtask

  task automatic do_reset(input logic mode);
    cur_req = "R12";
    rst = 1'b1;
    pipe_mode = mode;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b0, '0);
    rst = 1'b0;
    clear_model();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check(1'b0, '0);
  endtask

  task automatic t_basic(input logic mode);
    do_reset(mode);
    cur_req = mode ? "R2,R3" : "R1,R3";
    for (int i = 0; i < 4; i++) wr(AW'(8'h10 + i), DW'(36'h123456789 + i * 36'h11111), '0);
    idle(3);
    for (int i = 0; i < 4; i++) rd(AW'(8'h10 + i));
    rd(8'h12);
    idle(3);
  endtask

  task automatic t_turnaround(input logic mode);
    do_reset(mode);
    cur_req = "R4";
    wr(8'h20, 36'hA0A0A0A0A, '0);
    rd(8'h20);
    wr(8'h20, 36'h0000FFFFF, 4'b1100);
    rd(8'h20);
    wr(8'h21, 36'hC3C3C3C3C, '0);
    rd(8'h21);
    rd(8'h20);
    wr(8'h21, 36'h777777777, 4'b0110);
    wr(8'h20, 36'h111111111, '0);
    rd(8'h21);
    rd(8'h20);
    idle(3);
  endtask

  task automatic t_lanes();
    do_reset(1'b1);
    cur_req = "R5";
    wr(8'h30, 36'h2468ACE13, '0);
    idle(1);
    wr(8'h30, 36'hFDB975310, 4'b0101);
    wr(8'h30, 36'h000000000, 4'b1111);
    idle(2);
    rd(8'h30);
    idle(3);
  endtask

  task automatic t_chip_enable();
    do_reset(1'b0);
    cur_req = "R6";
    wr(8'h40, 36'h0BADCAFE1, '0);
    step(1'b0, 3'b110, 1'b0, '0, 8'h40, 36'hFFFFFFFFF);
    step(1'b0, 3'b000, 1'b0, '0, 8'h40, 36'hFFFFFFFFF);
    step(1'b0, 3'b011, 1'b0, '0, 8'h40, 36'hFFFFFFFFF);
    step(1'b0, 3'b011, 1'b1, '1, 8'h40, '0);
    step(1'b0, 3'b111, 1'b1, '1, 8'h40, '0);
    idle(2);
    rd(8'h40);
    idle(2);
  endtask

  task automatic t_burst(input logic mode, input logic ilv);
    do_reset(mode);
    burst_ilv = ilv;
    cur_req = ilv ? "R7,R9" : "R7,R8";
    wr(8'h51, 36'h100000001, '0);
    cont(36'h200000002);
    cont(36'h300000003);
    cont(36'h400000004);
    idle(3);
    for (int i = 0; i < 4; i++) rd(AW'(8'h50 + i));
    rd(8'h52);
    cont('0);
    cont('0);
    cont('0);
    idle(1);
    cont('0);
    cont('0);
    idle(3);
    burst_ilv = 1'b0;
  endtask

  task automatic t_oe();
    do_reset(1'b1);
    cur_req = "R10";
    wr(8'h60, 36'h600D600D6, '0);
    wr(8'h61, 36'h123123123, '0);
    idle(3);
    rd(8'h60);
    oe_n = 1'b1;
    rd(8'h61);
    oe_n = 1'b0;
    rd(8'h60);
    idle(1);
    oe_n = 1'b1;
    #1;
    check(1'b0, '0);
    oe_n = 1'b0;
    idle(2);
  endtask

  task automatic t_sleep();
    do_reset(1'b0);
    cur_req = "R11";
    wr(8'h70, 36'h5EE95EE95, '0);
    idle(2);
    sleep = 1'b1;
    wr(8'h70, 36'h000000000, '0);
    rd(8'h70);
    idle(1);
    sleep = 1'b0;
    rd(8'h70);
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_model();
    t_basic(1'b0);
    t_basic(1'b1);
    t_turnaround(1'b0);
    t_turnaround(1'b1);
    t_lanes();
    t_chip_enable();
    t_burst(1'b0, 1'b0);
    t_burst(1'b1, 1'b1);
    t_oe();
    t_sleep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule